// File: doc/BRIEF.md
# I2C Slave Receive Engine with Numeric Status Reporting

This block lets a host controller take part in an I2C bus as an addressed receiver. It oversamples the clock and data lines with the system clock and finds START, repeated START and STOP conditions. It shifts in the address byte after a START and compares it with a 7-bit programmable own address. When enabled, it also compares it with the all-zero general call address. On every bus event that needs software attention, it raises an interrupt flag and publishes an 8-bit status code. It then stretches the clock by holding SCL low until software clears the flag.

Software steers the transfer through three controls. It sets an acknowledge-enable level before clearing the flag, and that level decides whether the next data byte gets an ACK or a NOT ACK. A general-call enable decides whether address 0x00 is answered. A START request makes the block emit a one-cycle start pulse once the bus is free. This happens when the block drops back to the not-addressed state. Received bytes are presented on a registered data output.

Top module: `i2c_slave_rcv`

## Requirements
- R1: When the address byte equals the own address with write bit (LSB 0) and acknowledge-enable is 1, SDA is pulled low during the ninth clock, and the flag rises with status 0x60.
- R2: The address byte 0x00 is acknowledged with status 0x70 only when general-call enable and acknowledge-enable are both 1. Otherwise it gets no ACK and no flag.
- R3: If the arbitration-lost input is high when an address is accepted, the status is 0x68 for the own address or 0x78 for general call.
- R4: An address byte with a different 7-bit address, or the own address with read bit (LSB 1), gets no ACK and raises no flag.
- R5: While the flag is set, SCL is held low. A one-cycle clear pulse drops the flag and releases SCL.
- R6: Data bytes are received MSB first and shown on the data output. While addressed by the own address, the status is 0x80 after an ACK and 0x88 after a NOT ACK. The ACK is given exactly when acknowledge-enable was 1 at the preceding clear.
- R7: While addressed by general call, a data byte gives status 0x90 after an ACK and 0x98 after a NOT ACK.
- R8: A STOP or a repeated START seen in the addressed data phase gives status 0xA0. After a repeated START, the next byte is handled as an address.
- R9: Clearing after 0x88, 0x98 or a STOP-caused 0xA0 leaves the block not addressed, so a later STOP raises no flag. In this state the own address is answered only while acknowledge-enable is 1.
- R10: If the START request is 1 when a clear returns the block to the not-addressed state, exactly one start pulse is given, and only after the bus has become free (STOP seen).
- R11: After reset the flag is 0, the status is 0xF8, neither line is pulled and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_hold_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK) |
| own_addr_i | input | ADDR_W | Own 7-bit slave address |
| gc_en_i | input | 1 | Answer general call address 0x00 |
| ack_en_i | input | 1 | Acknowledge-enable level from software |
| flag_clr_i | input | 1 | One-cycle pulse that clears the flag |
| start_req_i | input | 1 | Request a START when back in not-addressed state |
| arb_lost_i | input | 1 | Master arbitration was lost before this address |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code of the last event |
| data_o | output | ADDR_W+1 | Last received data byte |
| start_go_o | output | 1 | One-cycle pulse asking the master side to issue START |

## Verification
A wrong internal state shows within one byte time. If recognition goes wrong, the ninth-clock ACK sampled by the bus master changes at once. If the addressed state is lost or kept too long, the next data byte or STOP produces a flag or status that should not be there, or misses one that should. The status code identifies the exact path taken, so a wrong mode or wrong ACK latch shows as a mismatching code on the very flag that follows. Start-request errors show as a start pulse count that is off before or after the STOP.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_WAIT
  } srx_state_t;

  localparam logic [7:0] SC_OWN_ACK = 8'h60;
  localparam logic [7:0] SC_OWN_ARB = 8'h68;
  localparam logic [7:0] SC_GC_ACK  = 8'h70;
  localparam logic [7:0] SC_GC_ARB  = 8'h78;
  localparam logic [7:0] SC_OD_ACK  = 8'h80;
  localparam logic [7:0] SC_OD_NAK  = 8'h88;
  localparam logic [7:0] SC_GD_ACK  = 8'h90;
  localparam logic [7:0] SC_GD_NAK  = 8'h98;
  localparam logic [7:0] SC_STOP    = 8'hA0;
  localparam logic [7:0] SC_NONE    = 8'hF8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '1;
      else     sh_q <= {sh_q[STAGES-1:0], raw_i[g]};
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
  end

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q  <= '0;
      data_o <= '0;
    end else if (shift_i && !full_o) begin
      data_o <= {data_o[W-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CW'(W));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W));

endmodule

// File: rtl/i2c_start_pend.sv
module i2c_start_pend (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic busy_i,
  output logic go_o
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      go_o   <= 1'b0;
    end else begin
      go_o <= 1'b0;
      if (arm_i) begin
        pend_q <= 1'b1;
      end else if (pend_q && !busy_i) begin
        pend_q <= 1'b0;
        go_o   <= 1'b1;
      end
    end
  end

  // R10
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    go_o |-> !pend_q);

  // R10
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);

endmodule

// File: rtl/i2c_slave_rcv.sv
module i2c_slave_rcv
  import i2c_srx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_hold_o,
  output logic              sda_pull_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  input  logic              ack_en_i,
  input  logic              flag_clr_i,
  input  logic              start_req_i,
  input  logic              arb_lost_i,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic [ADDR_W:0]   data_o,
  output logic              start_go_o
);

  localparam int BYTE_W = ADDR_W + 1;

  logic [1:0] raw, lvl, rise, fall;
  logic scl_hi, scl_r, scl_f, sda_lv, start_ev, stop_ev;

  assign raw = {sda_i, scl_i};

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_hi   = lvl[0];
  assign scl_r    = rise[0];
  assign scl_f    = fall[0];
  assign sda_lv   = lvl[1];
  assign start_ev = fall[1] & scl_hi;
  assign stop_ev  = rise[1] & scl_hi;

  srx_state_t st_q;
  logic [BYTE_W-1:0] sh_data;
  logic sh_full, sh_clr, sh_en;

  assign sh_clr = start_ev || !(st_q == ST_ADDR || st_q == ST_DATA);
  assign sh_en  = scl_r && (st_q == ST_ADDR || st_q == ST_DATA);

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (sh_clr),
    .shift_i (sh_en),
    .bit_i   (sda_lv),
    .data_o  (sh_data),
    .full_o  (sh_full)
  );

  logic busy_q, arm_q;

  always_ff @(posedge clk) begin
    if (rst)          busy_q <= 1'b0;
    else if (start_ev) busy_q <= 1'b1;
    else if (stop_ev)  busy_q <= 1'b0;
  end

  i2c_start_pend u_pend (
    .clk    (clk),
    .rst    (rst),
    .arm_i  (arm_q),
    .busy_i (busy_q),
    .go_o   (start_go_o)
  );

  // address compare
  logic own_hit, gc_hit;
  assign own_hit = (sh_data[BYTE_W-1:1] == own_addr_i) && !sh_data[0];
  assign gc_hit  = (sh_data == '0) && gc_en_i;

  logic mode_gc_q, ack_lat_q, ack_bit_q, addr_ph_q, arb_q, ack_ph_q, resume_q;
  logic [7:0] ev_code;

  always_comb begin
    if (addr_ph_q) begin
      if (mode_gc_q) ev_code = arb_q ? SC_GC_ARB : SC_GC_ACK;
      else           ev_code = arb_q ? SC_OWN_ARB : SC_OWN_ACK;
    end else begin
      if (mode_gc_q) ev_code = ack_bit_q ? SC_GD_ACK : SC_GD_NAK;
      else           ev_code = ack_bit_q ? SC_OD_ACK : SC_OD_NAK;
    end
  end

  logic stay_addr;
  assign stay_addr = (status_o == SC_OWN_ACK) || (status_o == SC_OWN_ARB) ||
                     (status_o == SC_GC_ACK)  || (status_o == SC_GC_ARB)  ||
                     (status_o == SC_OD_ACK)  || (status_o == SC_GD_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      mode_gc_q  <= 1'b0;
      ack_lat_q  <= 1'b0;
      ack_bit_q  <= 1'b0;
      addr_ph_q  <= 1'b0;
      arb_q      <= 1'b0;
      ack_ph_q   <= 1'b0;
      resume_q   <= 1'b0;
      sda_pull_o <= 1'b0;
      irq_o      <= 1'b0;
      status_o   <= SC_NONE;
      data_o     <= '0;
      arm_q      <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (st_q == ST_DATA && (start_ev || stop_ev)) begin
        irq_o    <= 1'b1;
        status_o <= SC_STOP;
        resume_q <= start_ev;
        st_q     <= ST_WAIT;
      end else if (start_ev && st_q != ST_WAIT) begin
        sda_pull_o <= 1'b0;
        ack_ph_q   <= 1'b0;
        st_q       <= ST_ADDR;
      end else if (stop_ev && st_q != ST_WAIT) begin
        sda_pull_o <= 1'b0;
        ack_ph_q   <= 1'b0;
        st_q       <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (sh_full) begin
              if (ack_en_i && (own_hit || gc_hit)) begin
                mode_gc_q <= !own_hit;
                addr_ph_q <= 1'b1;
                ack_bit_q <= 1'b1;
                arb_q     <= arb_lost_i;
                st_q      <= ST_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_DATA: begin
            if (sh_full) begin
              data_o    <= sh_data;
              addr_ph_q <= 1'b0;
              ack_bit_q <= ack_lat_q;
              st_q      <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_f) begin
              if (!ack_ph_q) begin
                sda_pull_o <= ack_bit_q;
                ack_ph_q   <= 1'b1;
              end else begin
                sda_pull_o <= 1'b0;
                ack_ph_q   <= 1'b0;
                irq_o      <= 1'b1;
                status_o   <= ev_code;
                resume_q   <= 1'b0;
                st_q       <= ST_WAIT;
              end
            end
          end
          ST_WAIT: begin
            if (flag_clr_i) begin
              irq_o     <= 1'b0;
              ack_lat_q <= ack_en_i;
              if (stay_addr) begin
                st_q <= ST_DATA;
              end else begin
                st_q  <= resume_q ? ST_ADDR : ST_IDLE;
                arm_q <= start_req_i;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_hold_o = irq_o;

  // R1
  ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
    sda_pull_o |-> (st_q == ST_ACK));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !flag_clr_i) |=> irq_o);

  // R8
  stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && stop_ev) |=> (irq_o && status_o == SC_STOP));

  // R9
  nak_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && flag_clr_i && (status_o == SC_OD_NAK || status_o == SC_GD_NAK))
      |=> (st_q == ST_IDLE));

  // R6
  code_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (status_o[2:0] == 3'b000 && status_o >= SC_OWN_ACK &&
                      status_o <= SC_STOP));

endmodule

// File: tb/i2c_slave_rcv_test.sv
module i2c_slave_rcv_test;

  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h4B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_hold, sda_pull, irq, start_go;
  logic gc_en = 1'b1, ack_en = 1'b1, flag_clr = 1'b0, start_req = 1'b0, arb_lost = 1'b0;
  logic [7:0] status, data;
  logic scl_line, sda_line;

  assign scl_line = m_scl & ~scl_hold;
  assign sda_line = m_sda & ~sda_pull;

  i2c_slave_rcv uut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_hold_o(scl_hold), .sda_pull_o(sda_pull), .own_addr_i(OWN),
    .gc_en_i(gc_en), .ack_en_i(ack_en), .flag_clr_i(flag_clr),
    .start_req_i(start_req), .arb_lost_i(arb_lost), .irq_o(irq),
    .status_o(status), .data_o(data), .start_go_o(start_go)
  );

  int n_run = 0, n_fail = 0, go_cnt = 0;
  bit cur_ae;

  always @(posedge clk) if (!rst && start_go) go_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input bit gc, input bit addr, input bit flag);
    if (addr) return gc ? (flag ? 8'h78 : 8'h70) : (flag ? 8'h68 : 8'h60);
    return gc ? (flag ? 8'h90 : 8'h98) : (flag ? 8'h80 : 8'h88);
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1;
      while (!scl_line) @(negedge clk);
      wq();
      m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = !sda_line;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic sw_clear(input bit ae);
    ack_en = ae;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one full receive transaction with random data and random ACK choices
  task automatic txn(input bit gc, input int nb);
    bit ack, alive;
    logic [7:0] d;
    ack_en = 1'b1;
    bus_start();
    put_byte(gc ? 8'h00 : {OWN, 1'b0}, ack);
    chk(gc ? "R2 gc addr ack" : "R1 own addr ack", ack, 1);
    chk(gc ? "R2 gc addr status" : "R1 own addr status", status, exp_code(gc, 1, 0));
    chk("R1 irq after addr", irq, 1);
    cur_ae = 1'($urandom % 2);
    sw_clear(cur_ae);
    alive = 1'b1;
    for (int k = 0; k < nb && alive; k++) begin
      d = 8'($urandom);
      put_byte(d, ack);
      chk(gc ? "R7 data ack" : "R6 data ack", ack, cur_ae);
      chk("R6 data value", data, d);
      chk(gc ? "R7 data status" : "R6 data status", status, exp_code(gc, 0, cur_ae));
      if (!cur_ae) begin
        alive = 1'b0;
        sw_clear(1'($urandom % 2));
      end else begin
        cur_ae = 1'($urandom % 2);
        sw_clear(cur_ae);
      end
    end
    bus_stop(); wq();
    if (alive) begin
      chk("R8 stop while addressed", {irq, status}, {1'b1, 8'hA0});
      sw_clear(1'b1);
    end else begin
      chk("R9 stop when not addressed", irq, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    int g0;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk("R11 irq", irq, 0);
    chk("R11 status", status, 8'hF8);
    chk("R11 lines", {scl_hold, sda_pull, start_go}, 0);
    chk("R11 data", data, 0);

    // R1 / R5 own address and clock stretch
    bus_start();
    put_byte({OWN, 1'b0}, ack);
    chk("R1 ack", ack, 1);
    chk("R1 status", status, 8'h60);
    chk("R5 hold", scl_hold, 1);
    m_scl = 1'b1; wq();
    chk("R5 scl stays low", scl_line, 0);
    m_scl = 1'b0; wq();
    sw_clear(1'b1);
    chk("R5 released", {irq, scl_hold}, 0);
    put_byte(8'hA5, ack);
    chk("R6 msb first", data, 8'hA5);
    chk("R6 ack code", status, 8'h80);
    sw_clear(1'b1);

    // R8 repeated start then address again
    bus_rstart();
    chk("R8 sr status", {irq, status}, {1'b1, 8'hA0});
    sw_clear(1'b1);
    put_byte({OWN, 1'b0}, ack);
    chk("R8 addr after sr", {ack, status}, {1'b1, 8'h60});
    sw_clear(1'b0);
    put_byte(8'h3C, ack);
    chk("R6 nack given", ack, 0);
    chk("R6 nack code", status, 8'h88);

    // R10 start request waits for bus free
    start_req = 1'b1;
    g0 = go_cnt;
    sw_clear(1'b1);
    start_req = 1'b0;
    wq();
    chk("R10 no pulse while busy", go_cnt, g0);
    bus_stop(); wq();
    chk("R10 one pulse after stop", go_cnt, g0 + 1);
    chk("R9 no flag after nack stop", irq, 0);

    // R3 arbitration-lost codes
    arb_lost = 1'b1;
    bus_start();
    put_byte({OWN, 1'b0}, ack);
    chk("R3 own arb", status, 8'h68);
    arb_lost = 1'b0;
    sw_clear(1'b1);
    bus_stop(); wq();
    chk("R8 stop after addr", status, 8'hA0);
    sw_clear(1'b1);
    arb_lost = 1'b1;
    bus_start();
    put_byte(8'h00, ack);
    chk("R3 gc arb", status, 8'h78);
    arb_lost = 1'b0;
    sw_clear(1'b1);
    bus_stop(); wq();
    sw_clear(1'b1);

    // R4 mismatch and read bit
    bus_start();
    put_byte({OWN ^ 7'h01, 1'b0}, ack);
    chk("R4 other addr", {ack, irq}, 0);
    bus_stop();
    bus_start();
    put_byte({OWN, 1'b1}, ack);
    chk("R4 read bit", {ack, irq}, 0);
    bus_stop();

    // R9 ack_en low blocks own address
    ack_en = 1'b0;
    bus_start();
    put_byte({OWN, 1'b0}, ack);
    chk("R9 ack_en low", {ack, irq}, 0);
    bus_stop();

    // R2 general call disabled
    ack_en = 1'b1;
    gc_en = 1'b0;
    bus_start();
    put_byte(8'h00, ack);
    chk("R2 gc disabled", {ack, irq}, 0);
    bus_stop();
    gc_en = 1'b1;

    // random transactions, R6 R7
    for (int t = 0; t < 10; t++) txn(1'($urandom % 2), 1 + int'($urandom % 4));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule